// File: doc/BRIEF.md
# Wait-State Bus Read Controller

This block is the read-cycle sequencer of a bus master. A core-side request with an address starts a read of an external memory. The block then steps through three phases, each one clock period long: an address phase (T1), an acknowledge phase (T2) and a data phase (T3). At the start of the cycle it drives the address and pulls the active-low chip-enable and output-enable strobes low. The chip enable disables the whole memory when it is high. The output enable only disables the memory's output driver when it is high.

The memory answers with an active-low acknowledge. The controller samples it on the rising edge that ends each T2 period. While the acknowledge is inactive, T2 repeats as a wait state. Once it is seen active, T3 follows. The read data is captured on the falling clock edge in the middle of T3, not on the edge that closes the cycle. A one-clock done pulse then returns the captured word to the core.

A programmable wait limit guards against a target that never answers. When the limit is reached, the cycle completes with an error flag instead of data. New requests are taken only while the controller is idle.

Top module: `waitstate_rd_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, mem_ce_n_o and mem_oe_n_o are 1, rd_done_o and rd_err_o are 0 and rd_data_o is 0.
- R2: When rd_req_i is 1 at a rising edge while the block is idle, the next clock period is T1. In T1, mem_addr_o equals the requested address and mem_ce_n_o and mem_oe_n_o are both 0. T1 lasts exactly one period and is always followed by T2.
- R3: mem_ce_n_o and mem_oe_n_o stay 0 and mem_addr_o stays constant from T1 to the end of the cycle. Both strobes return to 1 together in the period in which rd_done_o is 1.
- R4: mem_ack_n_i is sampled at the rising edge that ends each T2 period. A sampled 1, with the wait limit not yet reached, repeats T2 as a wait state, and the strobes stay 0.
- R5: A sampled 0 on mem_ack_n_i ends T2. The next period is T3, which lasts exactly one period.
- R6: With the default MID_CAPTURE = 1, mem_data_i is captured on the falling clock edge in the middle of T3. Values present before that edge, or after it within T3, do not reach rd_data_o.
- R7: After T3, rd_done_o is 1 for exactly one clock period. In that period rd_err_o is 0 and rd_data_o holds the captured word.
- R8: rd_req_i and rd_addr_i are ignored while a cycle is in progress. mem_addr_o does not change, and no further cycle follows the one in progress.
- R9: If mem_ack_n_i is still sampled 1 at the end of a T2 period after max_wait_i wait states have already been inserted (max_wait_i + 1 T2 periods in all), the cycle ends. rd_done_o and rd_err_o are both 1 for one period, the strobes return to 1, and rd_data_o keeps its previous value. With max_wait_i = 0, no wait state is allowed. max_wait_i must be held steady for the duration of a cycle.
- R10: A request presented in the period in which rd_done_o is 1 is accepted, because the block is already idle then. The next period is T1 of a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; phases advance on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Read request from the core, taken only when idle |
| rd_addr_i | input | ADDR_W | Read address from the core |
| max_wait_i | input | WAIT_W | Largest number of wait states before a bus error |
| mem_addr_o | output | ADDR_W | Address to the memory |
| mem_ce_n_o | output | 1 | Active-low chip enable |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_ack_n_i | input | 1 | Active-low acknowledge from the memory |
| mem_data_i | input | DATA_W | Read data bus from the memory |
| rd_data_o | output | DATA_W | Captured read word |
| rd_done_o | output | 1 | One-clock completion pulse |
| rd_err_o | output | 1 | Bus error flag, valid with rd_done_o |

## Verification
A phase register that skips or repeats a state shows up within one period. The strobes fall or rise a cycle off, or rd_done_o comes too early or too late, relative to the acknowledge the bench controls. A wait counter that miscounts moves the error completion by one period against the limit. The sweep over every wait count on both sides of each limit catches this on the first wrong case. A capture made on the wrong edge returns the complement of the expected word in the done period, because the bench keeps the valid data on the bus only around the falling edge of T3.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
   // Bus phases of one read cycle; IDLE sits between cycles.
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_T1   = 2'd1,
      PH_T2   = 2'd2,
      PH_T3   = 2'd3
   } phase_e;
endpackage

// File: rtl/rdc_phase_fsm.sv
module rdc_phase_fsm
   import rdc_pkg::*;
#(
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              ack_n_i,
   input  logic [WAIT_W-1:0] max_wait_i,
   output phase_e            phase_o,
   output phase_e            phase_nxt_o,
   output logic              end_ok_o,
   output logic              end_err_o
);
   phase_e            phase_q;
   phase_e            phase_d;
   logic [WAIT_W-1:0] wcnt_q;
   logic              limit_hit;

   assign limit_hit = (wcnt_q == max_wait_i);

   always_comb begin
      phase_d   = phase_q;
      end_ok_o  = 1'b0;
      end_err_o = 1'b0;
      unique case (phase_q)
         PH_IDLE: if (req_i) phase_d = PH_T1;
         PH_T1:   phase_d = PH_T2;
         PH_T2: begin
            if (!ack_n_i) begin
               phase_d = PH_T3;
            end else if (limit_hit) begin
               phase_d   = PH_IDLE;
               end_err_o = 1'b1;
            end
         end
         PH_T3: begin
            phase_d  = PH_IDLE;
            end_ok_o = 1'b1;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   // Wait states inserted so far in the current T2 stretch.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    wcnt_q <= '0;
      else if (phase_q != PH_T2)                     wcnt_q <= '0;
      else if (phase_d == PH_T2)                     wcnt_q <= wcnt_q + 1'b1;
   end

   assign phase_o     = phase_q;
   assign phase_nxt_o = phase_d;

   AST_REQ_STARTS_T1: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_IDLE && req_i) |=> (phase_q == PH_T1)); // R2
   AST_T1_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_T1) |=> (phase_q == PH_T2)); // R2
   AST_WAIT_REPEATS:  assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_T2 && ack_n_i && !limit_hit) |=> (phase_q == PH_T2)); // R4
   AST_ACK_TO_T3:     assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_T2 && !ack_n_i) |=> (phase_q == PH_T3)); // R5
   AST_T3_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_T3) |=> (phase_q == PH_IDLE)); // R5
   AST_TIMEOUT_END:   assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_T2 && ack_n_i && limit_hit) |=> (phase_q == PH_IDLE)); // R9
   AST_WAIT_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) (phase_q == PH_T2 && $stable(max_wait_i)) |-> (wcnt_q <= max_wait_i)); // R9
endmodule

// File: rtl/rdc_data_capture.sv
module rdc_data_capture #(
   parameter int DATA_W      = 8,
   parameter int MID_CAPTURE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_t3_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] cap_o
);
   generate
      if (MID_CAPTURE != 0) begin : g_mid
         // Falling edge inside T3 is the middle of the data phase.
         logic [DATA_W-1:0] mid_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)       mid_q <= '0;
            else if (in_t3_i) mid_q <= data_i;
         end
         assign cap_o = mid_q;
      end else begin : g_end
         // Variant: the word is taken by the rising edge closing T3.
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ in_t3_i;
         assign cap_o     = data_i;
      end
   endgenerate
endmodule

// File: rtl/rdc_bus_drive.sv
module rdc_bus_drive
   import rdc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase_i,
   input  phase_e            phase_nxt_i,
   input  logic              end_ok_i,
   input  logic              end_err_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] cap_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              ce_n_o,
   output logic              oe_n_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              done_o,
   output logic              err_o
);
   logic              ce_n_q, oe_n_q, done_q, err_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] rdata_q;
   logic              start;

   assign start = (phase_i == PH_IDLE) && (phase_nxt_i == PH_T1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_n_q  <= 1'b1;
         oe_n_q  <= 1'b1;
         addr_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ce_n_q <= (phase_nxt_i == PH_IDLE);
         oe_n_q <= (phase_nxt_i == PH_IDLE);
         done_q <= end_ok_i | end_err_i;
         err_q  <= end_err_i;
         if (start)    addr_q  <= addr_i;
         if (end_ok_i) rdata_q <= cap_i;
      end
   end

   assign mem_addr_o = addr_q;
   assign ce_n_o     = ce_n_q;
   assign oe_n_o     = oe_n_q;
   assign rdata_o    = rdata_q;
   assign done_o     = done_q;
   assign err_o      = err_q;

   AST_STROBE_PHASE: assert property (@(posedge clk) disable iff (!rst_n) (ce_n_q == (phase_i == PH_IDLE)) && (oe_n_q == ce_n_q)); // R3
   AST_ADDR_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (!ce_n_q && !$past(ce_n_q)) |-> $stable(addr_q)); // R3
   AST_RELEASE_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ce_n_q) |-> done_q); // R3
   AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q); // R7
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) err_q |-> done_q); // R9
endmodule

// File: rtl/waitstate_rd_ctrl.sv
module waitstate_rd_ctrl
   import rdc_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int WAIT_W      = 4,
   parameter int MID_CAPTURE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [WAIT_W-1:0] max_wait_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_ce_n_o,
   output logic              mem_oe_n_o,
   input  logic              mem_ack_n_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_done_o,
   output logic              rd_err_o
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("waitstate_rd_ctrl: ADDR_W and DATA_W must be at least 1");
      end
      if (WAIT_W < 1 || WAIT_W > 16) begin : g_bad_wait
         $error("waitstate_rd_ctrl: WAIT_W must lie in 1..16");
      end
      if (MID_CAPTURE != 0 && MID_CAPTURE != 1) begin : g_bad_cap
         $error("waitstate_rd_ctrl: MID_CAPTURE must be 0 or 1");
      end
   endgenerate

   phase_e            phase, phase_nxt;
   logic              end_ok, end_err;
   logic [DATA_W-1:0] cap;

   rdc_phase_fsm #(.WAIT_W(WAIT_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (rd_req_i),
      .ack_n_i    (mem_ack_n_i),
      .max_wait_i (max_wait_i),
      .phase_o    (phase),
      .phase_nxt_o(phase_nxt),
      .end_ok_o   (end_ok),
      .end_err_o  (end_err)
   );

   rdc_data_capture #(.DATA_W(DATA_W), .MID_CAPTURE(MID_CAPTURE)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_t3_i(phase == PH_T3),
      .data_i (mem_data_i),
      .cap_o  (cap)
   );

   rdc_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase_i    (phase),
      .phase_nxt_i(phase_nxt),
      .end_ok_i   (end_ok),
      .end_err_i  (end_err),
      .addr_i     (rd_addr_i),
      .cap_i      (cap),
      .mem_addr_o (mem_addr_o),
      .ce_n_o     (mem_ce_n_o),
      .oe_n_o     (mem_oe_n_o),
      .rdata_o    (rd_data_o),
      .done_o     (rd_done_o),
      .err_o      (rd_err_o)
   );

   AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) mem_ce_n_o == mem_oe_n_o); // R3
   AST_NO_DONE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !mem_ce_n_o |-> !rd_done_o); // R7
endmodule

// File: tb/tb_waitstate_rd_ctrl.sv
module tb_waitstate_rd_ctrl;
   localparam int AW = 12;
   localparam int DW = 8;
   localparam int WW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_req = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [WW-1:0] max_wait = '0;
   logic [AW-1:0] mem_addr;
   logic          ce_n, oe_n;
   logic          ack_n = 1'b1;
   logic [DW-1:0] mem_data = '0;
   logic [DW-1:0] rd_data;
   logic          done, err;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;
   logic [DW-1:0] last_data = '0;

   always #10 clk = ~clk;

   waitstate_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW), .MID_CAPTURE(1)) dut (
      .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
      .max_wait_i(max_wait), .mem_addr_o(mem_addr), .mem_ce_n_o(ce_n),
      .mem_oe_n_o(oe_n), .mem_ack_n_i(ack_n), .mem_data_i(mem_data),
      .rd_data_o(rd_data), .rd_done_o(done), .rd_err_o(err)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // Called 6 ns after a rising edge with the controller idle.
   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int nwait, input int maxw, input bit noise, input bit b2b);
      bit ok;
      int nt2;
      ok  = (nwait <= maxw);
      nt2 = ok ? nwait + 1 : maxw + 1;
      max_wait = maxw[WW-1:0];
      rd_addr  = a;
      rd_req   = 1'b1;
      mem_data = ~d;
      ack_n    = 1'b1;
      @(posedge clk); #4;
      rd_req  = 1'b0;
      rd_addr = ~a;
      #2;
      chk(b2b ? "R10" : "R2", "T1 ce_n", int'(ce_n), 0);
      chk("R2", "T1 oe_n", int'(oe_n), 0);
      chk("R2", "T1 address", int'(mem_addr), int'(a));
      chk("R7", "done low in T1", int'(done), 0);
      for (int k = 0; k < nt2; k++) begin
         @(posedge clk); #4;
         ack_n = (ok && k == nt2 - 1) ? 1'b0 : 1'b1;
         if (noise && k == 0) begin
            rd_req  = 1'b1;
            rd_addr = a ^ 12'h5A5;
         end
         #2;
         chk("R4", "T2 strobes low", int'({ce_n, oe_n}), 0);
         chk("R4", "T2 no done", int'(done), 0);
         chk(noise ? "R8" : "R3", "T2 address held", int'(mem_addr), int'(a));
      end
      if (ok) begin
         @(posedge clk); #4;
         ack_n    = 1'b1;
         rd_req   = 1'b0;
         mem_data = d;
         #2;
         chk("R5", "T3 strobes low", int'({ce_n, oe_n}), 0);
         chk("R5", "T3 no done", int'(done), 0);
         chk(noise ? "R8" : "R3", "T3 address held", int'(mem_addr), int'(a));
         #8;
         mem_data = ~d;
         @(posedge clk); #6;
         chk("R7", "done after T3", int'(done), 1);
         chk("R7", "no error", int'(err), 0);
         chk("R6", "mid-T3 data", int'(rd_data), int'(d));
         chk("R3", "strobes released", int'({ce_n, oe_n}), 3);
         last_data = d;
      end else begin
         @(posedge clk); #6;
         rd_req = 1'b0;
         chk("R9", "done on timeout", int'(done), 1);
         chk("R9", "error on timeout", int'(err), 1);
         chk("R9", "data kept", int'(rd_data), int'(last_data));
         chk("R9", "strobes released", int'({ce_n, oe_n}), 3);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #6;
      chk("R1", "reset strobes", int'({ce_n, oe_n}), 3);
      chk("R1", "reset done/err", int'({done, err}), 0);
      chk("R1", "reset data", int'(rd_data), 0);
      #0 rst_n = 1'b1;
      @(posedge clk); #6;
      chk("R1", "idle strobes", int'({ce_n, oe_n}), 3);
      chk("R1", "idle done", int'(done), 0);

      // Sweep each wait count against each limit, both sides of it.
      for (int mw = 0; mw < 4; mw++) begin
         for (int nw = 0; nw < 5; nw++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = AW'(12'h100 + mw * 16 + nw * 7);
            d = DW'(8'h3C ^ (mw * 37 + nw * 11));
            do_read(a, d, nw, mw, 1'b0, nw != 0);
         end
         @(posedge clk); #6;
         chk("R7", "done one period wide", int'(done), 0);
      end

      // Full-range limit: longest allowed wait, then one beyond.
      do_read(12'hABC, 8'h96, 7, 7, 1'b0, 1'b0);
      @(posedge clk); #6;
      do_read(12'h123, 8'h69, 8, 7, 1'b0, 1'b0);
      @(posedge clk); #6;

      // Requests during a cycle must leave no trace.
      do_read(12'h0F0, 8'hE1, 2, 3, 1'b1, 1'b0);
      @(posedge clk); #6;
      chk("R8", "no extra cycle", int'({ce_n, oe_n}), 3);
      chk("R8", "no extra done", int'(done), 0);
      do_read(12'h70F, 8'h1E, 3, 1, 1'b1, 1'b0);
      @(posedge clk); #6;
      chk("R8", "no extra cycle after error", int'({ce_n, oe_n}), 3);

      finish_run();
   end
endmodule